// File: doc/BRIEF.md
# Colour Palette Register Front End

This block is the processor-facing side of a 256-entry colour lookup table, together with the path that turns pixel codes into colours. Byte-wide reads and writes arrive on a two-bit port select. The four ports are the pixel mask, the read-mode index and state, the write-mode index, and the colour data. A single index register points into the table. A two-bit sub-index steps through the red, green and blue components. Each colour component is six bits wide.

Each clock, an 8-bit pixel code is ANDed with the mask and registered. The colour stored at the resulting address then appears on an 18-bit output. An enable input selects between the on-chip table and an external palette device. When it is low, mask and data accesses are not handled on chip. Instead, they are forwarded as active-low read and write strobes, and the on-chip state for those ports is left as it was.

Top module: `pal_dac_if`

## Requirements
- R1: After reset, the mask reads FFh, the status is 00, the index reads 0, the sub-index is 0, and both external strobes are high.
- R2: With the on-chip palette enabled, port select 0 (mask) is read/write and returns the last value written.
- R3: With the on-chip palette enabled, pix_rgb shows the entry at address (pix_in AND mask) one clock after pix_in is applied. With a mask of 07h, pixel 0Ah and pixel FAh both reach entry 2.
- R4: A write to port select 1 loads the index, clears the sub-index and sets the status to 11. A write to port select 2 loads the index, clears the sub-index and sets the status to 00. A read of port select 1 returns {6'b0, status}.
- R5: When enabled, each write to port select 3 stores data bits 5..0 into red, then green, then blue. The entry is packed {red, green, blue}, with red in bits 17..12. After blue, the index advances by one, wrapping from 255 to 0.
- R6: When enabled, each read of port select 3 returns red, then green, then blue, with bits 7..6 zero. After blue, the index advances by one.
- R7: When disabled, a read of port select 0 or 3 drives ext_rd_n low and returns 0 on cpu_rdata. A write to either port drives ext_wr_n low. The mask, index, sub-index and table stay unchanged.
- R8: A read of port select 1 never drives either external strobe low, whether the palette is enabled or disabled.
- R9: When disabled, the pixel lookup uses the unmasked pixel code.
- R10: A read of port select 2 returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_pal_en | input | 1 | 1 = on-chip palette owns the mask and data ports |
| cpu_addr | input | 2 | Port select: 0 mask, 1 read index/state, 2 write index, 3 data |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational during the access |
| ext_rd_n | output | 1 | Active-low read strobe to the external palette |
| ext_wr_n | output | 1 | Active-low write strobe to the external palette |
| mode_status | output | 2 | 00 after a write-index load, 11 after a read-index load |
| pix_in | input | 8 | Pixel code |
| pix_rgb | output | 18 | Looked-up colour {R,G,B}, one clock after pix_in |

## Verification
The hardest case to reach is the last one in R7. A disabled data write must leave both the sub-index and the table alone, yet neither is visible at the ports while the palette is disabled. To expose them, the stimulus first parks the index on a known entry with the sub-index at 0. It then issues disabled data accesses and re-enables the palette. Finally it reads the index and the next data byte; that byte must still be the untouched red component. The index wrap is reached by loading 254 and writing two full triplets.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        P_MASK = 2'd0,
        P_RIDX = 2'd1,
        P_WIDX = 2'd2,
        P_DATA = 2'd3
    } port_e;

    localparam logic [1:0] MODE_WR = 2'b00;
    localparam logic [1:0] MODE_RD = 2'b11;
    localparam int unsigned BUS_W = 8;
    localparam int unsigned NCOMP = 3;
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 6
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [1:0]               wsub,
    input  logic [IDX_W-1:0]         waddr,
    input  logic [COL_W-1:0]         wdata,
    input  logic [IDX_W-1:0]         cpu_addr,
    output logic [3*COL_W-1:0]       cpu_rgb,
    input  logic [IDX_W-1:0]         pix_addr,
    output logic [3*COL_W-1:0]       pix_rgb
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    // one bank per colour component; component 0 is red (top bits)
    for (genvar c = 0; c < 3; c++) begin : g_comp
        logic [COL_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wsub == 2'(c))) begin
                mem[waddr] <= wdata;
            end
        end

        assign cpu_rgb[(2-c)*COL_W +: COL_W] = mem[cpu_addr];
        assign pix_rgb[(2-c)*COL_W +: COL_W] = mem[pix_addr];
    end
endmodule

// File: rtl/pal_regs.sv
module pal_regs
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 int_en,
    input  logic [1:0]           addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [3*COL_W-1:0]   entry_rgb,
    output logic [IDX_W-1:0]     idx_q,
    output logic [IDX_W-1:0]     mask_q,
    output logic [1:0]           mode_q,
    output logic                 ram_we,
    output logic [1:0]           ram_sub,
    output logic [COL_W-1:0]     ram_wdata,
    output logic [BUS_W-1:0]     rdata
);
    typedef struct packed {
        logic [IDX_W-1:0] mask;
        logic [IDX_W-1:0] idx;
        logic [1:0]       sub;
        logic [1:0]       mode;
    } st_t;

    st_t st_d, st_q;
    logic [COL_W-1:0] comp;

    always_comb begin
        case (st_q.sub)
            2'd0:    comp = entry_rgb[3*COL_W-1 -: COL_W];
            2'd1:    comp = entry_rgb[2*COL_W-1 -: COL_W];
            default: comp = entry_rgb[COL_W-1:0];
        endcase
    end

    always_comb begin
        st_d   = st_q;
        rdata  = '0;
        ram_we = 1'b0;
        case (port_e'(addr))
            P_MASK: begin
                if (int_en) begin
                    if (wr) st_d.mask = wdata[IDX_W-1:0];
                    if (rd) rdata = BUS_W'(st_q.mask);
                end
            end
            P_RIDX: begin
                if (wr) begin
                    st_d.idx  = wdata[IDX_W-1:0];
                    st_d.sub  = 2'd0;
                    st_d.mode = MODE_RD;
                end
                if (rd) rdata = BUS_W'(st_q.mode);
            end
            P_WIDX: begin
                if (wr) begin
                    st_d.idx  = wdata[IDX_W-1:0];
                    st_d.sub  = 2'd0;
                    st_d.mode = MODE_WR;
                end
                if (rd) rdata = BUS_W'(st_q.idx);
            end
            default: begin
                if (int_en && (wr || rd)) begin
                    if (wr) ram_we = 1'b1;
                    if (rd) rdata = BUS_W'(comp);
                    if (st_q.sub == 2'd2) begin
                        st_d.sub = 2'd0;
                        st_d.idx = st_q.idx + 1'b1;
                    end else begin
                        st_d.sub = st_q.sub + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.idx  <= '0;
            st_q.sub  <= 2'd0;
            st_q.mode <= MODE_WR;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q     = st_q.idx;
    assign mask_q    = st_q.mask;
    assign mode_q    = st_q.mode;
    assign ram_sub   = st_q.sub;
    assign ram_wdata = wdata[COL_W-1:0];

    // R5
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sub <= 2'd2);

    // R4
    rmode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == P_RIDX) |=> (mode_q == MODE_RD && st_q.sub == 2'd0));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && wr && addr == P_DATA && st_q.sub == 2'd2)
        |=> (st_q.idx == $past(st_q.idx) + 1'b1 && st_q.sub == 2'd0));

    // R7
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && (wr || rd) && (addr == P_DATA || addr == P_MASK))
        |=> ($stable(st_q.idx) && $stable(st_q.sub) && $stable(st_q.mask)));
endmodule

// File: rtl/pal_dac_if.sv
module pal_dac_if
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned COL_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 int_pal_en,
    input  logic [1:0]           cpu_addr,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    input  logic [7:0]           cpu_wdata,
    output logic [7:0]           cpu_rdata,
    output logic                 ext_rd_n,
    output logic                 ext_wr_n,
    output logic [1:0]           mode_status,
    input  logic [IDX_W-1:0]     pix_in,
    output logic [3*COL_W-1:0]   pix_rgb
);
    logic [IDX_W-1:0]   idx, mask;
    logic               ram_we;
    logic [1:0]         ram_sub;
    logic [COL_W-1:0]   ram_wdata;
    logic [3*COL_W-1:0] cpu_rgb;
    logic [IDX_W-1:0]   pix_addr_d, pix_addr_q;
    logic               ext_sel;

    pal_regs #(.IDX_W(IDX_W), .COL_W(COL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_en    (int_pal_en),
        .addr      (cpu_addr),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata),
        .entry_rgb (cpu_rgb),
        .idx_q     (idx),
        .mask_q    (mask),
        .mode_q    (mode_status),
        .ram_we    (ram_we),
        .ram_sub   (ram_sub),
        .ram_wdata (ram_wdata),
        .rdata     (cpu_rdata)
    );

    pal_ram #(.IDX_W(IDX_W), .COL_W(COL_W)) u_ram (
        .clk      (clk),
        .we       (ram_we),
        .wsub     (ram_sub),
        .waddr    (idx),
        .wdata    (ram_wdata),
        .cpu_addr (idx),
        .cpu_rgb  (cpu_rgb),
        .pix_addr (pix_addr_q),
        .pix_rgb  (pix_rgb)
    );

    always_comb begin
        pix_addr_d = int_pal_en ? (pix_in & mask) : pix_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_addr_q <= '0;
        else        pix_addr_q <= pix_addr_d;
    end

    assign ext_sel  = !int_pal_en && (cpu_addr == P_MASK || cpu_addr == P_DATA);
    assign ext_rd_n = !(cpu_rd && ext_sel);
    assign ext_wr_n = !(cpu_wr && ext_sel);

    // R8
    state_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == P_RIDX) |-> (ext_rd_n && ext_wr_n));

    // R3
    pix_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_pal_en |=> (pix_addr_q == $past(pix_in & mask)));
endmodule

// File: tb/sim_pal_dac_if.sv
module sim_pal_dac_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_pal_en = 1'b1;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ext_rd_n, ext_wr_n;
    logic [1:0]  mode_status;
    logic [7:0]  pix_in = '0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [17:0] val;
        string       req;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    pal_dac_if u0 (
        .clk(clk), .rst_n(rst_n), .int_pal_en(int_pal_en),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .mode_status(mode_status), .pix_in(pix_in), .pix_rgb(pix_rgb)
    );

    // monitor: kinds 0 rdata, 1 pix_rgb, 2 {ext_rd_n,ext_wr_n}, 3 status
    always @(negedge clk) begin : mon
        item_t       it;
        logic [17:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                0:       act = {10'b0, cpu_rdata};
                1:       act = pix_rgb;
                2:       act = {16'b0, ext_rd_n, ext_wr_n};
                default: act = {16'b0, mode_status};
            endcase
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
            end
        end
    end

    task automatic exp_item(input int k, input logic [17:0] v, input string req);
        item_t it;
        it.kind = k; it.val = v; it.req = req;
        q.push_back(it);
    endtask

    task automatic acc(input logic [1:0] a, input logic r, input logic w, input logic [7:0] d);
        @(posedge clk); #2;
        cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        acc(a, 1'b0, 1'b1, d);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string req);
        acc(a, 1'b1, 1'b0, 8'h00);
        exp_item(0, {10'b0, e}, req);
    endtask

    task automatic pix_chk(input logic [7:0] p, input logic [17:0] e, input string req);
        idle();
        pix_in = p;
        idle();
        exp_item(1, e, req);
    endtask

    localparam logic [17:0] E2   = {6'h01, 6'h02, 6'h03};
    localparam logic [17:0] E10  = {6'h2A, 6'h15, 6'h3F};

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        idle();
        exp_item(3, 18'd0, "R1");
        exp_item(2, 18'd3, "R1");
        rd_chk(2'd0, 8'hFF, "R1");
        rd_chk(2'd2, 8'h00, "R1");

        // R5 write sequence into entry 2, then index advance
        wr_reg(2'd2, 8'd2);
        wr_reg(2'd3, 8'h01); wr_reg(2'd3, 8'h02); wr_reg(2'd3, 8'h03);
        rd_chk(2'd2, 8'd3, "R5");
        // entry 10 with upper data bits set on red
        wr_reg(2'd2, 8'd10);
        idle();
        exp_item(3, 18'd0, "R4");
        wr_reg(2'd3, 8'hEA); wr_reg(2'd3, 8'h15); wr_reg(2'd3, 8'h3F);
        rd_chk(2'd2, 8'd11, "R10");
        // R5 wrap 255 -> 0
        wr_reg(2'd2, 8'd254);
        for (int i = 4; i < 10; i++) wr_reg(2'd3, 8'(i));
        rd_chk(2'd2, 8'd0, "R5");

        // R4/R6 read mode
        wr_reg(2'd1, 8'd10);
        rd_chk(2'd1, 8'h03, "R4");
        rd_chk(2'd3, 8'h2A, "R6");
        rd_chk(2'd3, 8'h15, "R6");
        rd_chk(2'd3, 8'h3F, "R6");
        rd_chk(2'd2, 8'd11, "R6");
        wr_reg(2'd1, 8'd255);
        rd_chk(2'd3, 8'h07, "R6");
        rd_chk(2'd3, 8'h08, "R6");
        rd_chk(2'd3, 8'h09, "R6");
        rd_chk(2'd2, 8'd0, "R6");
        wr_reg(2'd2, 8'd0);
        rd_chk(2'd1, 8'h00, "R4");
        acc(2'd1, 1'b1, 1'b0, 8'h00);
        exp_item(2, 18'd3, "R8");

        // R3 pixel lookup and R2 mask
        pix_chk(8'd10, E10, "R3");
        wr_reg(2'd0, 8'h07);
        rd_chk(2'd0, 8'h07, "R2");
        pix_chk(8'd10, E2, "R3");
        pix_chk(8'hFA, E2, "R3");

        // R7 external ownership
        wr_reg(2'd2, 8'd2);
        idle();
        int_pal_en = 1'b0;
        acc(2'd0, 1'b1, 1'b0, 8'h00);
        exp_item(2, 18'd1, "R7");
        exp_item(0, 18'd0, "R7");
        acc(2'd0, 1'b0, 1'b1, 8'h00);
        exp_item(2, 18'd2, "R7");
        acc(2'd3, 1'b0, 1'b1, 8'h3F);
        exp_item(2, 18'd2, "R7");
        acc(2'd3, 1'b1, 1'b0, 8'h00);
        exp_item(2, 18'd1, "R7");
        exp_item(0, 18'd0, "R7");
        acc(2'd1, 1'b1, 1'b0, 8'h00);
        exp_item(2, 18'd3, "R8");
        pix_chk(8'd10, E10, "R9");
        idle();
        int_pal_en = 1'b1;
        rd_chk(2'd0, 8'h07, "R7");
        rd_chk(2'd2, 8'd2, "R7");
        rd_chk(2'd3, 8'h01, "R7");
        idle();
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule